// File: doc/BRIEF.md
# Lockable GPIO Controller with Interrupts

This block is a memory-mapped controller for 128 general-purpose lines, reached through a simple 32-bit register bus. Each line has its own configuration word. That word sets the drive value, turns the output driver and the input receiver on or off, and picks an interrupt mode. It also reports the synchronised input level. A lock bitmap, taken from a strap vector once after reset, makes chosen configuration words read-only. Interrupt status and enable bits are packed 32 lines to a word. One combined interrupt output is raised while any line is both pending and enabled.

Software reads offset 0 to find where the per-line configuration region starts. It configures each line through that region and services interrupts through the status and enable words. A pending bit is cleared by writing the status word with that bit at 0. Every pin input goes through a two-flop synchroniser before the controller samples it. Two trigger kinds exist: rising edge and active-high level.

A two-state control machine sequences start-up. `ST_CAPTURE` is entered on reset and loads the lock bitmap from the strap input. The transition `capture_done` moves it to `ST_RUN` on the next clock. `ST_RUN` is held until the next reset, and bus writes are honoured only in that state.

Top module: `gpio_lock_ctrl`

## Requirements
- R1: After reset every configuration word reads 0x00800018 (drive 0, output disabled, receiver disabled, mode 2). All status and enable bits read 0. `irq_o`, `gpio_out` and `gpio_oe` are 0.
- R2: The bus has these word-aligned byte addresses:
  - 0x000 returns the configuration base 0x200.
  - Lock word k is at 0x010+4k.
  - Status word k is at 0x020+4k.
  - Enable word k is at 0x030+4k.
  - The configuration word of line n is at 0x200+4n.
  - Bit j of word k covers line 32k+j.
  - Unmapped or unaligned addresses read 0.
  - Read data appears on `bus_rdata` one clock edge after the request.
- R3: Configuration word layout:
  - Bit 0 is the drive value and appears on `gpio_out`.
  - Bit 3 set disables the output, so `gpio_oe` is the inverse of bit 3.
  - Bit 4 set disables the receiver.
  - Bits 25:22 hold the interrupt mode.
  - Bit 1 reads the synchronised input level while the receiver is enabled and reads 0 otherwise.
  - All other bits read 0, and writes to them are dropped.
- R4: Writes to the configuration word of a locked line are ignored. Lock words cannot be written.
- R5: A pin change reaches the configuration readback bit 1 through two synchronising flops. A read issued in the cycle of the change, or in the cycle after it, still shows the old level. A read issued two cycles after the change shows the new level.
- R6: In mode 1 (edge), a status bit is set on a 0-to-1 transition of the synchronised input while the receiver is enabled. A falling transition sets nothing.
- R7: In mode 0 (level), a status bit is set on every cycle that the synchronised input is high and the receiver is enabled. Clearing the bit has no lasting effect while the input stays high.
- R8: Mode 2, and any mode value other than 0 and 1, never sets status. A line with its receiver disabled never sets status.
- R9: Writing a status word clears every bit written as 0 and keeps every bit written as 1. A new event in the same cycle wins over a clear.
- R10: `irq_o` is high exactly when some line has both its status bit and its enable bit set. A line whose enable bit is clear still records status.
- R11: Enable words are freely readable and writable.
- R12: The lock bitmap is loaded from `lock_strap` in `ST_CAPTURE`, the first cycle after reset. Later changes of `lock_strap` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lock_strap | input | 128 | Lock bitmap sampled after reset |
| gpio_in | input | 128 | Asynchronous pin levels |
| gpio_out | output | 128 | Drive values |
| gpio_oe | output | 128 | Output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Each result has its own due cycle:
- A read returns its data one edge after the request edge.
- A pin change shows in configuration bit 1 for a read issued two cycles later.
- A pin change shows in status and on `irq_o` three edges after the change.

The bench drives every input on the falling edge and samples on the falling edge. It samples both one cycle early (expecting the old value) and exactly on time (expecting the new value), so an extra or a missing register stage is caught. The sweep over all 128 configuration words checks the lock decode and the port outputs on the falling edge right after each write edge.

// File: rtl/gpl_pkg.sv
package gpl_pkg;
    localparam int CFG_DRIVE_BIT = 0;
    localparam int CFG_LEVEL_BIT = 1;
    localparam int CFG_TXDIS_BIT = 3;
    localparam int CFG_RXDIS_BIT = 4;
    localparam int CFG_MODE_LSB  = 22;
    localparam int MODE_W        = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_LEVEL = 4'd0,
        MODE_EDGE  = 4'd1,
        MODE_OFF   = 4'd2
    } irq_mode_e;

    typedef enum logic [0:0] {
        ST_CAPTURE = 1'b0,
        ST_RUN     = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/gpl_sync.sv
module gpl_sync #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/gpl_line.sv
module gpl_line
    import gpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_drive,
    input  logic              wr_txdis,
    input  logic              wr_rxdis,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic              lvl_i,
    output logic              drive_o,
    output logic              oe_o,
    output logic [31:0]       cfg_o,
    output logic              hit_o
);
    logic              drive_q;
    logic              txdis_q;
    logic              rxdis_q;
    logic [MODE_W-1:0] mode_q;
    logic              prev_q;
    logic              rx_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            txdis_q <= 1'b1;
            rxdis_q <= 1'b1;
            mode_q  <= MODE_OFF;
            prev_q  <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            if (wr_en) begin
                drive_q <= wr_drive;
                txdis_q <= wr_txdis;
                rxdis_q <= wr_rxdis;
                mode_q  <= wr_mode;
            end
        end
    end

    assign rx_lvl = lvl_i & ~rxdis_q;

    always_comb begin
        case (mode_q)
            MODE_LEVEL: hit_o = rx_lvl;
            MODE_EDGE:  hit_o = rx_lvl & ~prev_q;
            default:    hit_o = 1'b0;
        endcase
    end

    always_comb begin
        cfg_o = '0;
        cfg_o[CFG_DRIVE_BIT]                 = drive_q;
        cfg_o[CFG_LEVEL_BIT]                 = rx_lvl;
        cfg_o[CFG_TXDIS_BIT]                 = txdis_q;
        cfg_o[CFG_RXDIS_BIT]                 = rxdis_q;
        cfg_o[CFG_MODE_LSB +: MODE_W]        = mode_q;
    end

    assign drive_o = drive_q;
    assign oe_o    = ~txdis_q;
endmodule

// File: rtl/gpl_irq_word.sv
module gpl_irq_word #(
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] hit_i,
    input  logic             st_we,
    input  logic             en_we,
    input  logic [LANES-1:0] wdata,
    output logic [LANES-1:0] status_o,
    output logic [LANES-1:0] enable_o,
    output logic             pend_o
);
    logic [LANES-1:0] status_q;
    logic [LANES-1:0] enable_q;
    logic [LANES-1:0] keep_mask;

    assign keep_mask = st_we ? wdata : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & keep_mask) | hit_i;
            if (en_we) begin
                enable_q <= wdata;
            end
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign pend_o   = |(status_q & enable_q);
endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
    import gpl_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int ADDR_W    = 10,
    parameter int CFG_BASE  = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] lock_strap,
    input  logic [NUM_LINES-1:0] gpio_in,
    output logic [NUM_LINES-1:0] gpio_out,
    output logic [NUM_LINES-1:0] gpio_oe,
    output logic                 irq_o
);
    localparam int LANES     = 32;
    localparam int NUM_WORDS = NUM_LINES / LANES;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int LIDX_W    = $clog2(NUM_LINES);
    localparam int GRP_LSB   = 4;
    localparam int CFG_LSB   = LIDX_W + 2;
    localparam logic [ADDR_W-1:0] A_PTR  = '0;
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(32);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(48);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_BASE);

    // control state machine
    ctl_state_e state_q;
    ctl_state_e state_d;
    logic       capture_en;
    logic       bus_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CAPTURE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        capture_en = 1'b0;
        bus_open   = 1'b0;
        unique case (state_q)
            ST_CAPTURE: begin
                capture_en = 1'b1;
                state_d    = ST_RUN;   // capture_done
            end
            ST_RUN: begin
                bus_open = 1'b1;
            end
        endcase
    end

    // lock bitmap
    logic [NUM_LINES-1:0] lock_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (capture_en) begin
            lock_q <= lock_strap;
        end
    end

    // address decode
    logic               aligned;
    logic               hit_ptr;
    logic               hit_lock;
    logic               hit_stat;
    logic               hit_en;
    logic               hit_cfg;
    logic [WIDX_W-1:0]  widx;
    logic [LIDX_W-1:0]  lidx;
    logic               wr_go;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign hit_ptr  = (bus_addr == A_PTR);
    assign hit_lock = aligned && (bus_addr[ADDR_W-1:GRP_LSB] == A_LOCK[ADDR_W-1:GRP_LSB]);
    assign hit_stat = aligned && (bus_addr[ADDR_W-1:GRP_LSB] == A_STAT[ADDR_W-1:GRP_LSB]);
    assign hit_en   = aligned && (bus_addr[ADDR_W-1:GRP_LSB] == A_EN[ADDR_W-1:GRP_LSB]);
    assign hit_cfg  = aligned && (bus_addr[ADDR_W-1:CFG_LSB] == A_CFG[ADDR_W-1:CFG_LSB]);
    assign widx     = bus_addr[2 +: WIDX_W];
    assign lidx     = bus_addr[2 +: LIDX_W];
    assign wr_go    = bus_sel && bus_wr && bus_open;

    // input synchroniser
    logic [NUM_LINES-1:0] lvl_sync;
    gpl_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (gpio_in),
        .sync_o  (lvl_sync)
    );

    // per-line configuration
    logic [31:0]          cfg_rd [NUM_LINES];
    logic [NUM_LINES-1:0] hit_vec;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        logic line_we;
        assign line_we = wr_go && hit_cfg && (lidx == LIDX_W'(n)) && !lock_q[n];
        gpl_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (line_we),
            .wr_drive (bus_wdata[CFG_DRIVE_BIT]),
            .wr_txdis (bus_wdata[CFG_TXDIS_BIT]),
            .wr_rxdis (bus_wdata[CFG_RXDIS_BIT]),
            .wr_mode  (bus_wdata[CFG_MODE_LSB +: MODE_W]),
            .lvl_i    (lvl_sync[n]),
            .drive_o  (gpio_out[n]),
            .oe_o     (gpio_oe[n]),
            .cfg_o    (cfg_rd[n]),
            .hit_o    (hit_vec[n])
        );
    end

    // interrupt status and enable words
    logic [LANES-1:0]     st_w   [NUM_WORDS];
    logic [LANES-1:0]     en_w   [NUM_WORDS];
    logic [LANES-1:0]     lock_w [NUM_WORDS];
    logic [NUM_WORDS-1:0] pend_w;
    logic [NUM_LINES-1:0] status_q;
    logic [NUM_LINES-1:0] enable_q;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic st_we;
        logic en_we;
        assign st_we = wr_go && hit_stat && (widx == WIDX_W'(w));
        assign en_we = wr_go && hit_en   && (widx == WIDX_W'(w));
        gpl_irq_word #(.LANES(LANES)) u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit_i    (hit_vec[w*LANES +: LANES]),
            .st_we    (st_we),
            .en_we    (en_we),
            .wdata    (bus_wdata),
            .status_o (st_w[w]),
            .enable_o (en_w[w]),
            .pend_o   (pend_w[w])
        );
        assign lock_w[w]                   = lock_q[w*LANES +: LANES];
        assign status_q[w*LANES +: LANES]  = st_w[w];
        assign enable_q[w*LANES +: LANES]  = en_w[w];
    end

    assign irq_o = |pend_w;

    // read path
    logic [31:0] rd_comb;
    always_comb begin
        rd_comb = '0;
        if (hit_ptr) begin
            rd_comb = 32'(CFG_BASE);
        end else if (hit_lock) begin
            rd_comb = lock_w[widx];
        end else if (hit_stat) begin
            rd_comb = st_w[widx];
        end else if (hit_en) begin
            rd_comb = en_w[widx];
        end else if (hit_cfg) begin
            rd_comb = cfg_rd[lidx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_wr) begin
            bus_rdata <= rd_comb;
        end
    end
endmodule

// File: rtl/gpl_checker.sv
module gpl_checker
    import gpl_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int ADDR_W    = 10,
    parameter int CFG_BASE  = 512
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] gpio_oe,
    input logic                 irq_o,
    input logic [NUM_LINES-1:0] lock_q,
    input logic [NUM_LINES-1:0] status_q,
    input logic [NUM_LINES-1:0] enable_q,
    input ctl_state_e           state_q
);
    localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(32);

    assert_capture_to_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE) |=> (state_q == ST_RUN));

    assert_lock_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(lock_q));

    assert_locked_never_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ((gpio_oe & lock_q) == '0));

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (enable_q != '0));

    assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_q != '0));

    assert_ptr_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == '0)) |=> (bus_rdata == 32'(CFG_BASE)));

    assert_w0c_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (state_q == ST_RUN) && (bus_addr == A_STAT0))
        |=> ((status_q[31:0] & $past(status_q[31:0] & bus_wdata))
             == $past(status_q[31:0] & bus_wdata)));
endmodule

bind gpio_lock_ctrl gpl_checker #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .CFG_BASE  (CFG_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpio_oe   (gpio_oe),
    .irq_o     (irq_o),
    .lock_q    (lock_q),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .state_q   (state_q)
);

// File: tb/sim_gpio_lock_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_lock_ctrl;
    localparam int NL = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] lock_strap = '0;
    logic [NL-1:0] gpio_in = '0;
    logic [NL-1:0] gpio_out;
    logic [NL-1:0] gpio_oe;
    logic          irq_o;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    gpio_lock_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lock_strap(lock_strap), .gpio_in(gpio_in), .gpio_out(gpio_out),
        .gpio_oe(gpio_oe), .irq_o(irq_o)
    );

    function automatic logic locked(int i);
        return (i % 5) == 0;
    endfunction

    function automatic logic [31:0] lock_word(int k);
        logic [31:0] v = '0;
        for (int j = 0; j < 32; j++) v[j] = locked(32*k + j);
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [9:0] cfga(int n);
        return 10'(512 + 4*n);
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NL; i++) lock_strap[i] = locked(i);
        idle(3);
        rst_n = 1'b1;
        idle(2);
        lock_strap = ~lock_strap;   // must not matter any more (R12)

        // R1 reset state
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 oe", {31'b0, |gpio_oe}, 32'h0);
        chk("R1 out", {31'b0, |gpio_out}, 32'h0);
        for (int k = 0; k < 4; k++) begin
            rd(10'(32 + 4*k), rv); chk("R1 status", rv, 32'h0);
            rd(10'(48 + 4*k), rv); chk("R1 enable", rv, 32'h0);
            rd(10'(16 + 4*k), rv); chk("R12 lock word", rv, lock_word(k));
        end
        for (int n = 0; n < NL; n++) begin
            rd(cfga(n), rv); chk("R1 cfg reset", rv, 32'h0080_0018);
        end

        // R2 address map
        rd(10'h000, rv); chk("R2 pointer", rv, 32'h0000_0200);
        rd(10'h004, rv); chk("R2 unmapped 0x004", rv, 32'h0);
        rd(10'h040, rv); chk("R2 unmapped 0x040", rv, 32'h0);
        rd(10'h011, rv); chk("R2 unaligned", rv, 32'h0);

        // R3 / R4 sweep of every configuration word
        for (int n = 0; n < NL; n++) begin
            wr(cfga(n), 32'hF040_0FE5);
            chk("R3 gpio_out", {31'b0, gpio_out[n]}, locked(n) ? 32'h0 : 32'h1);
            chk("R4 gpio_oe", {31'b0, gpio_oe[n]}, locked(n) ? 32'h0 : 32'h1);
            rd(cfga(n), rv);
            chk(locked(n) ? "R4 locked cfg" : "R3 cfg fields", rv,
                locked(n) ? 32'h0080_0018 : 32'h0040_0001);
        end

        // R4 lock words are read-only, R12 strap change ignored
        wr(10'h010, 32'h0);
        rd(10'h010, rv); chk("R4 lock write ignored", rv, lock_word(0));

        // interrupt set-up
        wr(cfga(1), 32'h0040_0000);   // edge
        wr(cfga(2), 32'h0000_0000);   // level
        wr(cfga(3), 32'h0080_0000);   // mode 2
        wr(cfga(4), 32'h01C0_0000);   // mode 7
        wr(cfga(6), 32'h0040_0010);   // edge, receiver off
        wr(cfga(7), 32'h0040_0000);
        wr(cfga(8), 32'h0040_0000);
        wr(10'h030, 32'h0000_015E);
        rd(10'h030, rv); chk("R11 enable readback", rv, 32'h0000_015E);

        // R5 synchroniser latency, R6 edge timing
        gpio_in[1] = 1'b1;
        rd(cfga(1), rv); chk("R5 level after 1 edge", rv, 32'h0040_0000);
        rd(cfga(1), rv); chk("R5 level after 2 edges", rv, 32'h0040_0000);
        chk("R6 irq not yet", {31'b0, irq_o}, 32'h0);
        rd(cfga(1), rv); chk("R5 level after 3 edges", rv, 32'h0040_0002);
        chk("R6 irq on time", {31'b0, irq_o}, 32'h1);
        rd(10'h020, rv); chk("R6 status edge", rv, 32'h2);
        wr(10'h020, 32'hFFFF_FFFD);
        rd(10'h020, rv); chk("R6 edge cleared while high", rv, 32'h0);
        chk("R10 irq after clear", {31'b0, irq_o}, 32'h0);
        gpio_in[1] = 1'b0;
        idle(4);
        rd(10'h020, rv); chk("R6 falling ignored", rv, 32'h0);

        // R7 level mode, R9 set beats clear
        gpio_in[2] = 1'b1;
        idle(3);
        chk("R7 level irq", {31'b0, irq_o}, 32'h1);
        rd(10'h020, rv); chk("R7 level status", rv, 32'h4);
        wr(10'h020, 32'hFFFF_FFFB);
        rd(10'h020, rv); chk("R9 set beats clear", rv, 32'h4);
        gpio_in[2] = 1'b0;
        idle(3);
        wr(10'h020, 32'hFFFF_FFFB);
        rd(10'h020, rv); chk("R7 cleared after low", rv, 32'h0);
        chk("R7 irq low", {31'b0, irq_o}, 32'h0);

        // R8 modes that never set status, receiver disabled
        gpio_in[3] = 1'b1; gpio_in[4] = 1'b1; gpio_in[6] = 1'b1;
        idle(4);
        rd(10'h020, rv); chk("R8 no status", rv, 32'h0);
        chk("R8 irq", {31'b0, irq_o}, 32'h0);
        rd(cfga(6), rv); chk("R3 level hidden rx off", rv, 32'h0040_0010);
        rd(cfga(3), rv); chk("R3 level shown rx on", rv, 32'h0080_0002);
        gpio_in[3] = 1'b0; gpio_in[4] = 1'b0; gpio_in[6] = 1'b0;
        idle(3);

        // R10 status without enable, R9 keep-ones
        gpio_in[7] = 1'b1;
        idle(3);
        rd(10'h020, rv); chk("R10 status recorded", rv, 32'h80);
        chk("R10 irq masked", {31'b0, irq_o}, 32'h0);
        gpio_in[8] = 1'b1;
        idle(3);
        rd(10'h020, rv); chk("R10 two pending", rv, 32'h180);
        chk("R10 irq enabled", {31'b0, irq_o}, 32'h1);
        wr(10'h020, 32'hFFFF_FEFF);
        rd(10'h020, rv); chk("R9 keep ones", rv, 32'h80);
        chk("R10 irq after clear", {31'b0, irq_o}, 32'h0);
        wr(10'h020, 32'h0);
        rd(10'h020, rv); chk("R9 clear all", rv, 32'h0);

        // second word, line 33
        wr(10'h034, 32'h2);
        rd(10'h034, rv); chk("R11 enable word1", rv, 32'h2);
        gpio_in[33] = 1'b1;
        idle(3);
        chk("R10 irq word1", {31'b0, irq_o}, 32'h1);
        rd(10'h024, rv); chk("R2 status word1 bit", rv, 32'h2);
        wr(10'h024, 32'h0);
        chk("R9 irq word1 cleared", {31'b0, irq_o}, 32'h0);

        rd(10'h01C, rv); chk("R12 lock word3 kept", rv, lock_word(3));

        finish_run();
    end
endmodule